// File: doc/BRIEF.md
# Chained Two-Stage Pacer Programming Sequencer

This block sets up two channels of a three-channel 16-bit interval timer as one 32-bit rate generator, where the first stage's output clocks the second stage. A request carries an on/off flag and the two channel indices. The block turns it into an ordered series of byte writes toward the timer's register port. Channel data registers sit at addresses 0 to 2 and the control register sits at address 3.

Two 17-bit pending divisors are taken in. A commit strobe copies them, after a clamp, into the current divisors used by later enable sequences. Each channel also has a reservation flag. The flag is set when a channel becomes part of a running pacer and cleared when that pacer is switched off. A general-purpose access port asks whether a channel may be touched and gets a refusal while that channel is reserved.

The write stream is valid/ready. The block raises `bus_wvalid` with an address and byte and holds all three steady until `bus_wready` is seen high at a clock edge. At most one write completes per cycle, and a low ready simply stalls the sequence. A one-cycle `seq_done` pulse follows the final accepted write.

Top module: `pacer_cascade_seq`

## Requirements
- R1: A request whose channel indices are equal, or where either index is 3, raises `req_rejected` for one cycle after the edge that samples it and produces no bus write.
- R2: An enable request (`pace_on`=1) issues six writes in this order: control word for stage 1, control word for stage 2, stage-2 divisor, then stage-1 divisor. The stage-2 divisor goes to the stage-2 channel address and the stage-1 divisor to the stage-1 channel address. Each enable control word is `{ch[1:0], 2'b11, 3'b010, 1'b0}` (periodic rate mode, low-then-high access, binary).
- R3: A disable request (`pace_on`=0) issues only two writes, both to address 3: the stage-1 control word and then the stage-2 control word, each `{ch[1:0], 2'b11, 3'b000, 1'b0}` (count-to-terminal mode, binary).
- R4: Each divisor is written as two writes to the same channel address, the low byte first and then the high byte.
- R5: On `div_commit`, each current divisor becomes the pending value clamped to the range 2..65536 and then truncated to 16 bits. Pending values 0 and 1 give 2, and 65536 or more gives 0. The enable sequence writes the current divisors as they stood when the request was accepted.
- R6: While `bus_wvalid` is high and `bus_wready` is low, `bus_wvalid`, `bus_waddr` and `bus_wdata` stay unchanged on the next cycle.
- R7: `seq_done` pulses for exactly one cycle, the cycle after the last write of a sequence is accepted.
- R8: A request that arrives while a sequence is in progress is ignored: it adds no writes and no rejection.
- R9: Accepting an enable request sets `ch_busy` for both named channels on the next cycle. Completing a disable sequence clears `ch_busy` for both of its channels.
- R10: `gp_refused` is high exactly when `gp_req` is high and `gp_ch` names a busy channel or equals 3.
- R11: After reset, `bus_wvalid`, `seq_done`, `req_rejected` and all `ch_busy` bits are 0, and both current divisors are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pace_req | input | 1 | Request strobe, sampled only while idle |
| pace_on | input | 1 | 1 = start pacer, 0 = stop pacer |
| stage1_ch | input | 2 | Channel index of the first (fast) stage |
| stage2_ch | input | 2 | Channel index of the second stage |
| stage1_pend | input | 17 | Pending divisor for stage 1 |
| stage2_pend | input | 17 | Pending divisor for stage 2 |
| div_commit | input | 1 | Copies the clamped pending divisors into the current divisors |
| bus_wvalid | output | 1 | Write transaction valid |
| bus_wready | input | 1 | Timer port accepts the write |
| bus_waddr | output | 2 | Register address (0..2 channel data, 3 control) |
| bus_wdata | output | 8 | Byte to write |
| seq_done | output | 1 | One-cycle pulse after the final write of a sequence |
| req_rejected | output | 1 | One-cycle pulse for an invalid request |
| ch_busy | output | 3 | Per-channel reservation flags |
| gp_req | input | 1 | General-purpose access attempt |
| gp_ch | input | 2 | Channel targeted by the access attempt |
| gp_refused | output | 1 | Access attempt refused |

## Verification
The assertions check on every cycle that a stalled write holds its payload, that a disable sequence never touches a data address, and that an invalid request leads to a rejection pulse and no write. They also check that `seq_done` follows the final acceptance, that the latched request cannot change mid-sequence, that a commit never leaves a divisor of 1, and that reservations appear after an enable. The exact order of the six writes, the byte split of each divisor, the clamp results at 0, 1, 65536 and 131071, and the dropping of a request made during a stall come from the scenario scoreboard. That scoreboard runs under random back-pressure.

// File: rtl/pacer_pkg.sv
package pacer_pkg;
  localparam int CH_W     = 2;
  localparam int N_CH     = 3;
  localparam int BYTE_W   = 8;
  localparam int DIV_W    = 16;
  localparam int PEND_W   = DIV_W + 1;
  localparam int STEP_W   = 3;
  localparam logic [CH_W-1:0] CTRL_ADDR = 2'd3;

  // Sequence steps for an enable; a disable stops after STEP_CTRL2.
  typedef enum logic [STEP_W-1:0] {
    STEP_CTRL1 = 3'd0,
    STEP_CTRL2 = 3'd1,
    STEP_S2_LO = 3'd2,
    STEP_S2_HI = 3'd3,
    STEP_S1_LO = 3'd4,
    STEP_S1_HI = 3'd5
  } step_t;

  // Control byte: channel select, low-then-high access, mode, binary.
  function automatic logic [BYTE_W-1:0] ctrl_byte(input logic [CH_W-1:0] ch,
                                                  input logic periodic);
    return {ch, 2'b11, (periodic ? 3'b010 : 3'b000), 1'b0};
  endfunction
endpackage

// File: rtl/pacer_div_bank.sv
module pacer_div_bank
  import pacer_pkg::*;
#(
  parameter int LANES = 2
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    commit,
  input  logic [LANES*PEND_W-1:0] pend,
  output logic [LANES*DIV_W-1:0]  cur
);
  localparam logic [PEND_W-1:0] MIN_DIV = PEND_W'(2);
  localparam logic [PEND_W-1:0] MAX_DIV = PEND_W'(1) << DIV_W;

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    logic [PEND_W-1:0] p, clamped;
    logic [DIV_W-1:0]  q;
    assign p = pend[g*PEND_W +: PEND_W];
    always_comb begin
      clamped = p;
      if (p < MIN_DIV) clamped = MIN_DIV;
      else if (p > MAX_DIV) clamped = MAX_DIV;
    end
    always_ff @(posedge clk) begin
      if (!rst_n) q <= '0;
      else if (commit) q <= clamped[DIV_W-1:0];
    end
    assign cur[g*DIV_W +: DIV_W] = q;

    assert_commit_not_one_R5: assert property (@(posedge clk) disable iff (!rst_n)
      commit |=> (q != DIV_W'(1)));
  end
endmodule

// File: rtl/pacer_seq_fsm.sv
module pacer_seq_fsm
  import pacer_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic            req,
  input  logic            req_on,
  input  logic [CH_W-1:0] req_a,
  input  logic [CH_W-1:0] req_b,
  input  logic            ready,
  output logic            active,
  output step_t           step,
  output logic            lat_on,
  output logic [CH_W-1:0] lat_a,
  output logic [CH_W-1:0] lat_b,
  output logic            start,
  output logic            fin,
  output logic            done,
  output logic            reject
);
  localparam logic [CH_W-1:0] TOP_CH = CH_W'(N_CH - 1);

  logic  req_ok, last_step;
  step_t step_nx;

  assign req_ok    = (req_a <= TOP_CH) && (req_b <= TOP_CH) && (req_a != req_b);
  assign start     = !active && req && req_ok;
  assign last_step = lat_on ? (step == STEP_S1_HI) : (step == STEP_CTRL2);
  assign fin       = active && ready && last_step;
  assign step_nx   = step_t'(step + 1'b1);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      active <= 1'b0;
      step   <= STEP_CTRL1;
      lat_on <= 1'b0;
      lat_a  <= '0;
      lat_b  <= '0;
      done   <= 1'b0;
      reject <= 1'b0;
    end else begin
      done   <= 1'b0;
      reject <= 1'b0;
      if (!active) begin
        if (req && req_ok) begin
          active <= 1'b1;
          step   <= STEP_CTRL1;
          lat_on <= req_on;
          lat_a  <= req_a;
          lat_b  <= req_b;
        end else if (req) begin
          reject <= 1'b1;
        end
      end else if (ready) begin
        if (last_step) begin
          active <= 1'b0;
          done   <= 1'b1;
        end else begin
          step <= step_nx;
        end
      end
    end
  end

  assert_bad_req_rejected_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (!active && req && !req_ok) |=> (reject && !active));
  assert_done_after_last_R7: assert property (@(posedge clk) disable iff (!rst_n)
    fin |=> (done && !active));
  assert_busy_req_ignored_R8: assert property (@(posedge clk) disable iff (!rst_n)
    active |=> ($stable(lat_on) && $stable(lat_a) && $stable(lat_b) && !reject));
endmodule

// File: rtl/pacer_busy_map.sv
module pacer_busy_map
  import pacer_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic            set_en,
  input  logic [CH_W-1:0] set_a,
  input  logic [CH_W-1:0] set_b,
  input  logic            clr_en,
  input  logic [CH_W-1:0] clr_a,
  input  logic [CH_W-1:0] clr_b,
  input  logic            gp_req,
  input  logic [CH_W-1:0] gp_ch,
  output logic [N_CH-1:0] busy,
  output logic            gp_refused
);
  localparam int PAD = (1 << CH_W);

  for (genvar c = 0; c < N_CH; c++) begin : g_ch
    logic hit_set, hit_clr;
    assign hit_set = set_en && ((set_a == CH_W'(c)) || (set_b == CH_W'(c)));
    assign hit_clr = clr_en && ((clr_a == CH_W'(c)) || (clr_b == CH_W'(c)));
    always_ff @(posedge clk) begin
      if (!rst_n)       busy[c] <= 1'b0;
      else if (hit_set) busy[c] <= 1'b1;
      else if (hit_clr) busy[c] <= 1'b0;
    end
  end

  logic [PAD-1:0] busy_pad;
  assign busy_pad   = {{(PAD-N_CH){1'b1}}, busy};
  assign gp_refused = gp_req && busy_pad[gp_ch];

  assert_enable_reserves_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (set_en && set_a < CH_W'(N_CH) && set_b < CH_W'(N_CH))
      |=> ($countones(busy) >= 2));
endmodule

// File: rtl/pacer_cascade_seq.sv
module pacer_cascade_seq
  import pacer_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              pace_req,
  input  logic              pace_on,
  input  logic [CH_W-1:0]   stage1_ch,
  input  logic [CH_W-1:0]   stage2_ch,
  input  logic [PEND_W-1:0] stage1_pend,
  input  logic [PEND_W-1:0] stage2_pend,
  input  logic              div_commit,
  output logic              bus_wvalid,
  input  logic              bus_wready,
  output logic [CH_W-1:0]   bus_waddr,
  output logic [BYTE_W-1:0] bus_wdata,
  output logic              seq_done,
  output logic              req_rejected,
  output logic [N_CH-1:0]   ch_busy,
  input  logic              gp_req,
  input  logic [CH_W-1:0]   gp_ch,
  output logic              gp_refused
);
  logic [2*DIV_W-1:0] cur;
  logic [DIV_W-1:0]   snap1, snap2;
  logic               active, lat_on, start, fin;
  logic [CH_W-1:0]    lat_a, lat_b;
  step_t              step;

  pacer_div_bank #(.LANES(2)) u_div (
    .clk(clk), .rst_n(rst_n), .commit(div_commit),
    .pend({stage2_pend, stage1_pend}), .cur(cur)
  );

  pacer_seq_fsm u_fsm (
    .clk(clk), .rst_n(rst_n), .req(pace_req), .req_on(pace_on),
    .req_a(stage1_ch), .req_b(stage2_ch), .ready(bus_wready),
    .active(active), .step(step), .lat_on(lat_on), .lat_a(lat_a), .lat_b(lat_b),
    .start(start), .fin(fin), .done(seq_done), .reject(req_rejected)
  );

  pacer_busy_map u_busy (
    .clk(clk), .rst_n(rst_n),
    .set_en(start && pace_on), .set_a(stage1_ch), .set_b(stage2_ch),
    .clr_en(fin && !lat_on), .clr_a(lat_a), .clr_b(lat_b),
    .gp_req(gp_req), .gp_ch(gp_ch), .busy(ch_busy), .gp_refused(gp_refused)
  );

  // Divisors frozen at request acceptance so a mid-sequence commit cannot split a pair.
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      snap1 <= '0;
      snap2 <= '0;
    end else if (start) begin
      snap1 <= cur[0 +: DIV_W];
      snap2 <= cur[DIV_W +: DIV_W];
    end
  end

  assign bus_wvalid = active;

  always_comb begin
    bus_waddr = CTRL_ADDR;
    bus_wdata = '0;
    unique case (step)
      STEP_CTRL1: begin bus_waddr = CTRL_ADDR; bus_wdata = ctrl_byte(lat_a, lat_on); end
      STEP_CTRL2: begin bus_waddr = CTRL_ADDR; bus_wdata = ctrl_byte(lat_b, lat_on); end
      STEP_S2_LO: begin bus_waddr = lat_b; bus_wdata = snap2[BYTE_W-1:0]; end
      STEP_S2_HI: begin bus_waddr = lat_b; bus_wdata = snap2[DIV_W-1:BYTE_W]; end
      STEP_S1_LO: begin bus_waddr = lat_a; bus_wdata = snap1[BYTE_W-1:0]; end
      STEP_S1_HI: begin bus_waddr = lat_a; bus_wdata = snap1[DIV_W-1:BYTE_W]; end
      default:    begin bus_waddr = CTRL_ADDR; bus_wdata = '0; end
    endcase
  end

  assert_stall_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wvalid && !bus_wready) |=>
      (bus_wvalid && $stable(bus_waddr) && $stable(bus_wdata)));
  assert_disable_ctrl_only_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wvalid && !lat_on) |-> (bus_waddr == CTRL_ADDR));
  assert_rate_mode_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wvalid && lat_on && bus_waddr == CTRL_ADDR) |-> (bus_wdata[3:0] == 4'b0100));
endmodule

// File: tb/pacer_cascade_seq_test.sv
module pacer_cascade_seq_test;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        pace_req = 1'b0, pace_on = 1'b0;
  logic [1:0]  stage1_ch = '0, stage2_ch = '0;
  logic [16:0] stage1_pend = '0, stage2_pend = '0;
  logic        div_commit = 1'b0;
  logic        bus_wvalid, bus_wready;
  logic [1:0]  bus_waddr;
  logic [7:0]  bus_wdata;
  logic        seq_done, req_rejected, gp_refused;
  logic [2:0]  ch_busy;
  logic        gp_req = 1'b0;
  logic [1:0]  gp_ch = '0;

  int checks = 0, fails = 0;
  logic [9:0] exp_q[$];
  string      exp_tag[$];
  logic       stall = 1'b0, bp = 1'b0;
  logic [7:0] lfsr = 8'hA5;
  logic [15:0] m_cur1 = '0, m_cur2 = '0;

  always #(CLK_PERIOD/2) clk = ~clk;
  initial bus_wready = 1'b1;

  pacer_cascade_seq uut (.*);

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [15:0] clampmask(input logic [16:0] p);
    if (p < 17'd2) return 16'd2;
    if (p > 17'h10000) return 16'd0;
    return p[15:0];
  endfunction

  function automatic logic [7:0] cw(input logic [1:0] ch, input bit on);
    return {ch, 2'b11, (on ? 3'b010 : 3'b000), 1'b0};
  endfunction

  task automatic push(input logic [1:0] a, input logic [7:0] d, input string tag);
    exp_q.push_back({a, d});
    exp_tag.push_back(tag);
  endtask

  // Monitor / scoreboard: drives ready, then compares each accepted write.
  always @(negedge clk) begin
    lfsr <= {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
    bus_wready <= stall ? 1'b0 : (bp ? lfsr[0] : 1'b1);
    #1;
    if (rst_n && bus_wvalid && bus_wready) begin
      if (exp_q.size() == 0) begin
        check(1'b0, "R8/R1 unexpected write", {bus_waddr, bus_wdata}, 0);
      end else begin
        logic [9:0] e;
        string t;
        e = exp_q.pop_front();
        t = exp_tag.pop_front();
        check({bus_waddr, bus_wdata} == e, t, {bus_waddr, bus_wdata}, e);
      end
    end
  end

  task automatic commit(input logic [16:0] p1, input logic [16:0] p2);
    @(negedge clk);
    stage1_pend = p1; stage2_pend = p2; div_commit = 1'b1;
    @(negedge clk);
    div_commit = 1'b0;
    m_cur1 = clampmask(p1); m_cur2 = clampmask(p2);
  endtask

  task automatic issue(input bit on, input logic [1:0] a, input logic [1:0] b);
    @(negedge clk);
    pace_req = 1'b1; pace_on = on; stage1_ch = a; stage2_ch = b;
    @(negedge clk);
    pace_req = 1'b0;
  endtask

  task automatic wait_done(input string req);
    int n = 0;
    while (!seq_done && n < 200) begin
      @(negedge clk);
      n++;
    end
    check(seq_done == 1'b1, {req, " R7 done pulse"}, seq_done, 1);
    check(exp_q.size() == 0, {req, " R7 all writes before done"}, exp_q.size(), 0);
    @(negedge clk);
    check(seq_done == 1'b0, "R7 done one cycle", seq_done, 0);
  endtask

  task automatic run_enable(input logic [1:0] a, input logic [1:0] b);
    push(2'd3, cw(a, 1), "R2 ctrl stage1");
    push(2'd3, cw(b, 1), "R2 ctrl stage2");
    push(b, m_cur2[7:0], "R4 stage2 low");
    push(b, m_cur2[15:8], "R4 stage2 high");
    push(a, m_cur1[7:0], "R5 stage1 low");
    push(a, m_cur1[15:8], "R5 stage1 high");
    issue(1'b1, a, b);
    wait_done("R2");
  endtask

  task automatic run_disable(input logic [1:0] a, input logic [1:0] b);
    push(2'd3, cw(a, 0), "R3 ctrl stage1");
    push(2'd3, cw(b, 0), "R3 ctrl stage2");
    issue(1'b0, a, b);
    wait_done("R3");
  endtask

  task automatic bad_req(input logic [1:0] a, input logic [1:0] b);
    @(negedge clk);
    pace_req = 1'b1; pace_on = 1'b1; stage1_ch = a; stage2_ch = b;
    @(negedge clk);
    pace_req = 1'b0;
    check(req_rejected == 1'b1, "R1 reject pulse", req_rejected, 1);
    repeat (3) @(negedge clk);
    check(bus_wvalid == 1'b0, "R1 no write", bus_wvalid, 0);
  endtask

  initial begin
    #(CLK_PERIOD * 20000);
    check(1'b0, "watchdog", 0, 1);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check(bus_wvalid == 0 && seq_done == 0 && req_rejected == 0, "R11 idle outputs",
          {bus_wvalid, seq_done, req_rejected}, 0);
    check(ch_busy == 3'b000, "R11 busy clear", ch_busy, 0);

    // R11: divisors reset to 0 show up as zero bytes on an enable.
    m_cur1 = 16'd0; m_cur2 = 16'd0;
    run_enable(2'd0, 2'd1);
    check(ch_busy == 3'b011, "R9 busy after enable", ch_busy, 3'b011);
    run_disable(2'd0, 2'd1);
    check(ch_busy == 3'b000, "R9 busy cleared by disable", ch_busy, 0);

    // R5: clamp at both ends, under random back-pressure (R6).
    bp = 1'b1;
    commit(17'd1, 17'h10000);
    run_enable(2'd2, 2'd0);
    commit(17'd0, 17'h1FFFF);
    run_disable(2'd2, 2'd0);
    run_enable(2'd1, 2'd2);
    commit(17'h1234, 17'h0ABCD);
    run_disable(2'd1, 2'd2);
    run_enable(2'd0, 2'd2);
    bp = 1'b0;

    // R10 general-purpose access while channels 0 and 2 are reserved.
    gp_req = 1'b1; gp_ch = 2'd0; #1;
    check(gp_refused == 1'b1, "R10 busy ch refused", gp_refused, 1);
    gp_ch = 2'd1; #1;
    check(gp_refused == 1'b0, "R10 free ch allowed", gp_refused, 0);
    gp_ch = 2'd3; #1;
    check(gp_refused == 1'b1, "R10 index 3 refused", gp_refused, 1);
    gp_req = 1'b0; #1;
    check(gp_refused == 1'b0, "R10 no request", gp_refused, 0);
    run_disable(2'd0, 2'd2);

    // R1 invalid requests.
    bad_req(2'd1, 2'd1);
    bad_req(2'd3, 2'd0);
    bad_req(2'd0, 2'd3);
    check(ch_busy == 3'b000, "R1 no reservation", ch_busy, 0);

    // R8: request during a stalled sequence is dropped.
    stall = 1'b1;
    push(2'd3, cw(2'd1, 1), "R8 ctrl stage1");
    push(2'd3, cw(2'd0, 1), "R8 ctrl stage2");
    push(2'd0, m_cur2[7:0], "R8 stage2 low");
    push(2'd0, m_cur2[15:8], "R8 stage2 high");
    push(2'd1, m_cur1[7:0], "R8 stage1 low");
    push(2'd1, m_cur1[15:8], "R8 stage1 high");
    issue(1'b1, 2'd1, 2'd0);
    repeat (2) @(negedge clk);
    issue(1'b0, 2'd1, 2'd0);
    check(req_rejected == 1'b0, "R8 no reject while active", req_rejected, 0);
    check(bus_wvalid == 1'b1, "R6 valid held under stall", bus_wvalid, 1);
    stall = 1'b0;
    wait_done("R8");
    repeat (4) @(negedge clk);
    check(ch_busy == 3'b011, "R8 disable dropped, busy kept", ch_busy, 3'b011);
    check(bus_wvalid == 1'b0, "R8 no extra sequence", bus_wvalid, 0);

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule